// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block gives a host processor a way to reach a small bank of PHY delay settings through one packed 32-bit control word. The word sits in a 1 KiB register window, and the rest of the window reads as zero. Software places a PHY register index and a write value in the word. It then sets a write or a read request bit and polls a completion flag. When the flag reads 1, software clears the request bit again. The handshake is carried out entirely in software-visible bits. It does not use any bus-level wait states.

The port detects the rising edge of each request bit. It performs exactly one transfer to or from the delay bank for that edge and holds the completion flag for as long as the request bit stays set. Read results are latched into a read-only byte of the word. The bank drives its current settings out on a flat bus toward the delay lines. An index that the bank does not implement still completes normally. This keeps a polling loop from ever hanging.

Top module: `phy_access_port`

## Requirements
- R1: After reset, the control word reads 0x0000_0000 and every delay output byte is zero.
- R2: The control word answers only at byte offset 0x10 of the window. A read of any other offset returns zero, and a write to any other offset leaves the control word unchanged.
- R3: Control word layout: bits 7:0 hold the register index, bits 15:8 the write value, bits 23:16 the read result (read-only), bit 24 the write request, bit 25 the read request and bit 26 the completion flag (read-only). Bits 31:27 read as zero.
- R4: A 0-to-1 change of the write request stores the write value into the indexed register. The completion flag is still 0 at the clock edge that follows the host write that set the request. It reads 1 after the edge after that.
- R5: The delay output byte of a register (bits 8*i+7:8*i of the flat bus) takes the new value on the same edge on which the completion flag rises, and it changes at no other time.
- R6: The completion flag stays 1 while the committed request bit stays 1. It reads 0 no later than the second edge after the host write that clears that request.
- R7: A 0-to-1 change of the read request copies the indexed register into bits 23:16, so the value is valid when the completion flag reads 1. That byte then keeps its value through later writes, until the next read completes.
- R8: Indices 0x09, 0x0A and 0x0E to 0xFF are unimplemented. Accesses to them still complete with the flag. A write to them changes no output, and a read from them returns zero.
- R9: If the write and read requests rise in the same host write, only the write is performed. The read result byte is unchanged, and the flag follows the write request.
- R10: Rewriting the control word while a request bit is already 1 starts no new transfer. A changed write value is not stored.
- R11: Indices 0x00 to 0x08 and 0x0B to 0x0D are implemented, and each holds its own independent 8-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write enable for the addressed word |
| host_addr | input | WIN_AW (10) | Byte offset within the register window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the addressed word (combinational) |
| phy_dly | output | NUM_REGS*DLY_W (128) | All delay register values, index i in bits 8*i+7:8*i |

## Verification
The bench builds the port with its default parameters: a 16-entry bank of 8-bit registers with the implemented-index mask 0x39FF and the control word at offset 0x10. With these values, both index gaps of the mask (0x09 and 0x0A) fall inside the bank. So do the top indices 0x0E and 0x0F, and the full 8-bit index field reaches past the end of the bank (0x40). This means every kind of unimplemented access can be exercised next to the twelve real registers. The directed scenarios cover:
- the exact cycle at which the flag rises;
- the release of the flag;
- simultaneous requests;
- rewrites while a request is held.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;

   // Field placement inside the packed control word (software contract)
   localparam int FLD_IDX_LSB  = 0;
   localparam int FLD_WVAL_LSB = 8;
   localparam int FLD_RVAL_LSB = 16;
   localparam int BIT_WREQ     = 24;
   localparam int BIT_RREQ     = 25;
   localparam int BIT_DONE     = 26;
   localparam int FLD_W        = 8;

   typedef enum logic [1:0] {
      XF_IDLE    = 2'd0,
      XF_HOLD_WR = 2'd1,
      XF_HOLD_RD = 2'd2
   } xfer_state_e;

   typedef struct packed {
      logic             rreq;
      logic             wreq;
      logic [FLD_W-1:0] wval;
      logic [FLD_W-1:0] idx;
   } host_cmd_t;

endpackage

// File: rtl/phyp_host_regs.sv
module phyp_host_regs
   import phy_port_pkg::*;
#(
   parameter int WIN_AW   = 10,
   parameter int CTRL_OFS = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [WIN_AW-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   input  logic              rd_capture,
   input  logic [FLD_W-1:0]  bank_rval,
   input  logic              done,
   output host_cmd_t         cmd,
   output logic [31:0]       ctrl_word,
   output logic [31:0]       host_rdata
);

   localparam int WORD_AW = WIN_AW - 2;
   localparam logic [WORD_AW-1:0] CTRL_WORD_IDX = WORD_AW'(CTRL_OFS >> 2);

   logic             hit;
   logic [FLD_W-1:0] rval_q;

   assign hit = (host_addr[WIN_AW-1:2] == CTRL_WORD_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd <= '0;
      end else if (host_we && hit) begin
         cmd.idx  <= host_wdata[FLD_IDX_LSB  +: FLD_W];
         cmd.wval <= host_wdata[FLD_WVAL_LSB +: FLD_W];
         cmd.wreq <= host_wdata[BIT_WREQ];
         cmd.rreq <= host_wdata[BIT_RREQ];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rval_q <= '0;
      end else if (rd_capture) begin
         rval_q <= bank_rval;
      end
   end

   always_comb begin
      ctrl_word                             = '0;
      ctrl_word[FLD_IDX_LSB  +: FLD_W]      = cmd.idx;
      ctrl_word[FLD_WVAL_LSB +: FLD_W]      = cmd.wval;
      ctrl_word[FLD_RVAL_LSB +: FLD_W]      = rval_q;
      ctrl_word[BIT_WREQ]                   = cmd.wreq;
      ctrl_word[BIT_RREQ]                   = cmd.rreq;
      ctrl_word[BIT_DONE]                   = done;
   end

   assign host_rdata = hit ? ctrl_word : 32'h0;

endmodule

// File: rtl/phyp_xfer_fsm.sv
module phyp_xfer_fsm
   import phy_port_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wreq,
   input  logic rreq,
   output logic bank_we,
   output logic rd_capture,
   output logic done
);

   xfer_state_e state_q, state_d;
   logic        wreq_q, rreq_q;
   logic        wr_rise, rd_rise;

   assign wr_rise = wreq & ~wreq_q;
   assign rd_rise = rreq & ~rreq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wreq_q  <= 1'b0;
         rreq_q  <= 1'b0;
         state_q <= XF_IDLE;
      end else begin
         wreq_q  <= wreq;
         rreq_q  <= rreq;
         state_q <= state_d;
      end
   end

   always_comb begin
      state_d    = state_q;
      bank_we    = 1'b0;
      rd_capture = 1'b0;
      unique case (state_q)
         XF_IDLE: begin
            // write request wins when both rise together
            if (wr_rise) begin
               bank_we = 1'b1;
               state_d = XF_HOLD_WR;
            end else if (rd_rise) begin
               rd_capture = 1'b1;
               state_d    = XF_HOLD_RD;
            end
         end
         XF_HOLD_WR: if (!wreq) state_d = XF_IDLE;
         XF_HOLD_RD: if (!rreq) state_d = XF_IDLE;
         default:    state_d = XF_IDLE;
      endcase
   end

   assign done = (state_q != XF_IDLE);

endmodule

// File: rtl/phyp_dly_bank.sv
module phyp_dly_bank
   import phy_port_pkg::*;
#(
   parameter int                    NUM_REGS  = 16,
   parameter int                    DLY_W     = 8,
   parameter logic [NUM_REGS-1:0]   IMPL_MASK = 16'h39FF
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [FLD_W-1:0]          idx,
   input  logic [FLD_W-1:0]          wval,
   output logic [FLD_W-1:0]          rval,
   output logic [NUM_REGS*DLY_W-1:0] dly_flat
);

   logic [DLY_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (IMPL_MASK[i]) begin : g_impl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[i] <= '0;
            end else if (we && (idx == FLD_W'(i))) begin
               regs[i] <= wval[DLY_W-1:0];
            end
         end
      end else begin : g_hole
         assign regs[i] = '0;
      end
      assign dly_flat[i*DLY_W +: DLY_W] = regs[i];
   end

   always_comb begin
      rval = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == FLD_W'(i)) rval = FLD_W'(regs[i]);
      end
   end

endmodule

// File: rtl/phy_access_port.sv
module phy_access_port
   import phy_port_pkg::*;
#(
   parameter int                  WIN_AW    = 10,
   parameter int                  CTRL_OFS  = 'h10,
   parameter int                  SLOT_BASE = 'h200,
   parameter int                  NUM_REGS  = 16,
   parameter int                  DLY_W     = 8,
   parameter logic [NUM_REGS-1:0] IMPL_MASK = 16'h39FF
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_we,
   input  logic [WIN_AW-1:0]         host_addr,
   input  logic [31:0]               host_wdata,
   output logic [31:0]               host_rdata,
   output logic [NUM_REGS*DLY_W-1:0] phy_dly
);

   localparam int WIN_BYTES = 1 << WIN_AW;

   if (CTRL_OFS % 4 != 0) begin : g_bad_align
      $error("CTRL_OFS must be word aligned");
   end
   if (CTRL_OFS >= SLOT_BASE || SLOT_BASE > WIN_BYTES) begin : g_bad_map
      $error("control word must lie below the slot region inside the window");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << FLD_W)) begin : g_bad_depth
      $error("NUM_REGS must fit the 8-bit index field");
   end
   if (DLY_W < 1 || DLY_W > FLD_W) begin : g_bad_width
      $error("DLY_W must fit the 8-bit value fields");
   end

   host_cmd_t        cmd;
   logic [31:0]      ctrl_word;
   logic             bank_we, rd_capture, done;
   logic [FLD_W-1:0] bank_rval;

   phyp_host_regs #(
      .WIN_AW   (WIN_AW),
      .CTRL_OFS (CTRL_OFS)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .rd_capture (rd_capture),
      .bank_rval  (bank_rval),
      .done       (done),
      .cmd        (cmd),
      .ctrl_word  (ctrl_word),
      .host_rdata (host_rdata)
   );

   phyp_xfer_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wreq       (cmd.wreq),
      .rreq       (cmd.rreq),
      .bank_we    (bank_we),
      .rd_capture (rd_capture),
      .done       (done)
   );

   phyp_dly_bank #(
      .NUM_REGS  (NUM_REGS),
      .DLY_W     (DLY_W),
      .IMPL_MASK (IMPL_MASK)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bank_we),
      .idx      (cmd.idx),
      .wval     (cmd.wval),
      .rval     (bank_rval),
      .dly_flat (phy_dly)
   );

endmodule

// File: rtl/phy_access_port_chk.sv
module phy_access_port_chk
   import phy_port_pkg::*;
#(
   parameter int                  NUM_REGS  = 16,
   parameter int                  DLY_W     = 8,
   parameter logic [NUM_REGS-1:0] IMPL_MASK = 16'h39FF
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [31:0]               ctrl_word,
   input logic [NUM_REGS*DLY_W-1:0] phy_dly
);

   logic             wreq, rreq, done, idx_impl;
   logic [FLD_W-1:0] idx, rval;

   assign wreq = ctrl_word[BIT_WREQ];
   assign rreq = ctrl_word[BIT_RREQ];
   assign done = ctrl_word[BIT_DONE];
   assign idx  = ctrl_word[FLD_IDX_LSB  +: FLD_W];
   assign rval = ctrl_word[FLD_RVAL_LSB +: FLD_W];

   always_comb begin
      idx_impl = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == FLD_W'(i)) idx_impl = IMPL_MASK[i];
      end
   end

   // R4: completion only follows a pending request
   p_done_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(wreq || rreq));

   // R6: no request pending, flag gone on the next edge
   p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wreq && !rreq) |=> !done);

   // R7: read byte moves only when a transfer completes
   p_rval_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(done) |-> $stable(rval));

   // R5: delay outputs move only when a transfer completes
   p_dly_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(done) |-> $stable(phy_dly));

   // R8: read of an unimplemented index returns zero
   p_hole_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && $past(rreq && !wreq && !idx_impl)) |-> (rval == '0));

endmodule

bind phy_access_port phy_access_port_chk #(
   .NUM_REGS  (NUM_REGS),
   .DLY_W     (DLY_W),
   .IMPL_MASK (IMPL_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_word (ctrl_word),
   .phy_dly   (phy_dly)
);

// File: tb/sim_phy_access_port.sv
module sim_phy_access_port;

   localparam int CLK_PERIOD = 10;
   localparam logic [9:0] CTRL = 10'h010;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_we = 1'b0;
   logic [9:0]   host_addr = CTRL;
   logic [31:0]  host_wdata = '0;
   logic [31:0]  host_rdata;
   logic [127:0] phy_dly;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   logic [7:0] exp_reg [16];
   logic [7:0] exp_rval = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_access_port u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .phy_dly    (phy_dly)
   );

   function automatic bit is_impl(input int a);
      return (a <= 8) || (a >= 11 && a <= 13);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0; host_addr = CTRL;
   endtask

   task automatic peek(input logic [9:0] a, output logic [31:0] v);
      host_addr = a;
      #1;
      v = host_rdata;
      host_addr = CTRL;
   endtask

   task automatic chk_outputs(input string req);
      for (int i = 0; i < 16; i++)
         chk(phy_dly[i*8 +: 8] == exp_reg[i], req, phy_dly[i*8 +: 8], exp_reg[i]);
   endtask

   // full write handshake: value, set request, poll, clear
   task automatic phy_write(input logic [7:0] a, input logic [7:0] d);
      logic [31:0] v;
      bus_wr(CTRL, {16'h0, d, a});
      bus_wr(CTRL, {7'h0, 1'b1, 8'h0, d, a});
      peek(CTRL, v);
      chk(v[26] == 1'b0, "R4 flag not yet", v[26], 0);
      step();
      peek(CTRL, v);
      chk(v[26] == 1'b1, "R4 flag raised", v[26], 1);
      if (a < 16 && is_impl(a)) exp_reg[a] = d;
      chk_outputs("R5");
      step(); step();
      peek(CTRL, v);
      chk(v[26] == 1'b1, "R6 flag held", v[26], 1);
      bus_wr(CTRL, {16'h0, d, a});
      step();
      peek(CTRL, v);
      chk(v[26] == 1'b0, "R6 flag released", v[26], 0);
   endtask

   task automatic phy_read(input logic [7:0] a, input logic [7:0] exp, input string req);
      logic [31:0] v;
      bus_wr(CTRL, {16'h0, 8'h00, a});
      bus_wr(CTRL, {6'h0, 1'b1, 1'b0, 8'h0, 8'h00, a});
      step();
      peek(CTRL, v);
      chk(v[26] == 1'b1, {req, " read flag"}, v[26], 1);
      chk(v[23:16] == exp, {req, " read value"}, v[23:16], exp);
      exp_rval = exp;
      bus_wr(CTRL, {16'h0, 8'h00, a});
      step();
      peek(CTRL, v);
      chk(v[26] == 1'b0, "R6 read flag released", v[26], 0);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      peek(CTRL, v);
      chk(v == 32'h0, "R1 word", v, 0);
      chk(phy_dly == '0, "R1 outputs", phy_dly, 0);
   endtask

   task automatic t_offsets();
      logic [31:0] v;
      bus_wr(10'h014, 32'h0000_5A5A);
      bus_wr(10'h200, 32'h0000_1234);
      peek(CTRL, v);
      chk(v == 32'h0, "R2 foreign write ignored", v, 0);
      bus_wr(CTRL, 32'h0000_00AB);
      peek(10'h014, v);
      chk(v == 32'h0, "R2 other offset reads zero", v, 0);
      peek(10'h00C, v);
      chk(v == 32'h0, "R2 offset 0x0C reads zero", v, 0);
      peek(CTRL, v);
      chk(v == 32'h0000_00AB, "R2 control word hit", v, 32'hAB);
   endtask

   task automatic t_fields();
      logic [31:0] v;
      bus_wr(CTRL, 32'h0000_A55A);
      peek(CTRL, v);
      chk(v == 32'h0000_A55A, "R3 index and value", v, 32'hA55A);
      bus_wr(CTRL, 32'hFCFF_3412);
      peek(CTRL, v);
      chk(v == 32'h0000_3412, "R3 read-only and reserved bits", v, 32'h3412);
      bus_wr(CTRL, 32'h0);
   endtask

   task automatic t_all_regs();
      for (int a = 0; a < 16; a++)
         if (is_impl(a)) phy_write(8'(a), 8'(8'h11 + a * 13));
      chk_outputs("R11 all registers");
      for (int a = 0; a < 16; a++)
         if (is_impl(a)) phy_read(8'(a), exp_reg[a], "R11");
   endtask

   task automatic t_rval_hold();
      logic [31:0] v;
      phy_read(8'h0B, exp_reg[11], "R7");
      phy_write(8'h02, 8'h9C);
      peek(CTRL, v);
      chk(v[23:16] == exp_rval, "R7 read byte held over write", v[23:16], exp_rval);
      phy_read(8'h02, 8'h9C, "R7");
   endtask

   task automatic t_holes();
      logic [31:0] v;
      phy_write(8'h09, 8'h77);
      phy_write(8'h0E, 8'h66);
      phy_write(8'hC0, 8'h55);
      chk_outputs("R8 hole writes discarded");
      phy_read(8'h0D, exp_reg[13], "R8 preload");
      phy_read(8'h0A, 8'h00, "R8 hole");
      phy_read(8'h0D, exp_reg[13], "R8 preload");
      phy_read(8'h40, 8'h00, "R8 beyond bank");
      peek(CTRL, v);
      chk(v[26] == 1'b0, "R8 idle after holes", v[26], 0);
   endtask

   task automatic t_both();
      logic [31:0] v;
      phy_read(8'h01, exp_reg[1], "R9 preload");
      bus_wr(CTRL, {16'h0, 8'hC3, 8'h03});
      bus_wr(CTRL, {6'h0, 2'b11, 8'h0, 8'hC3, 8'h03});
      step();
      peek(CTRL, v);
      exp_reg[3] = 8'hC3;
      chk(v[26] == 1'b1, "R9 flag", v[26], 1);
      chk(v[23:16] == exp_rval, "R9 read ignored", v[23:16], exp_rval);
      chk_outputs("R9 write done");
      bus_wr(CTRL, {6'h0, 2'b10, 8'h0, 8'hC3, 8'h03});
      step();
      peek(CTRL, v);
      chk(v[26] == 1'b0, "R9 flag follows write request", v[26], 0);
      chk(v[23:16] == exp_rval, "R9 still no read", v[23:16], exp_rval);
      bus_wr(CTRL, 32'h0);
   endtask

   task automatic t_no_rise();
      logic [31:0] v;
      phy_write(8'h04, 8'h21);
      bus_wr(CTRL, {16'h0, 8'h5E, 8'h04});
      bus_wr(CTRL, {7'h0, 1'b1, 8'h0, 8'h5E, 8'h04});
      step();
      exp_reg[4] = 8'h5E;
      bus_wr(CTRL, {7'h0, 1'b1, 8'h0, 8'hE7, 8'h04});
      step(); step();
      peek(CTRL, v);
      chk(v[26] == 1'b1, "R10 flag stays", v[26], 1);
      chk(phy_dly[4*8 +: 8] == 8'h5E, "R10 no second store",
          phy_dly[4*8 +: 8], 8'h5E);
      bus_wr(CTRL, 32'h0);
      step();
      phy_read(8'h04, 8'h5E, "R10");
   endtask

   initial begin
      for (int i = 0; i < 16; i++) exp_reg[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_offsets();
      t_fields();
      t_all_regs();
      t_rval_hold();
      t_holes();
      t_both();
      t_no_rise();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule